// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a faster main clock. Two counters are chained. The first is a power-of-two prescaler whose ratio is picked by a 2-bit select. The second divides the prescaler ticks by a programmable count that the 6-bit baud value sets. Each time the second counter wraps, the serial clock changes level.

Besides the clock itself, the block emits two one-cycle strobes in the main clock domain. One marks the cycle in which the serial clock moves away from its idle level. The other marks the cycle in which it returns. A neighbouring shifter uses these strobes to sample and launch data for either clock phase, without detecting edges on the serial clock.

The divider settings and the polarity bit are captured into shadow registers only while the enable is low. A transfer in progress therefore always runs at one fixed rate. Working out the settings from a requested frequency is left to software. Data shifting belongs to the neighbouring shifter.

Top module: `spiclk_gen`

## Requirements
- R1: With the shadowed prescale select D (0..3) and the shadowed baud value B, each half-period of `sck` lasts H = 2^(D+1)·(B+1) main-clock cycles. After `en` is first sampled high, the first departure from idle happens on the H-th rising edge at which `en` is sampled high, and the return to idle happens on edge 2H. H therefore ranges from 10 to 1024 cycles.
- R2: A baud value below 4 behaves exactly as 4. Values 4 to 63 are used unchanged.
- R3: While `rst` is high, `sck` is 0 and both strobes are 0. Reset loads the shadow settings D=0, B=4 and polarity 0. If `en` is held high through reset, these defaults govern the first transfer (H=10).
- R4: While disabled, `sck` sits at the shadowed polarity, which follows `cpol` one cycle later: 1 means idle high, 0 means idle low. While enabled, `sck` stays at that idle level until the first departure.
- R5: `lead_pulse` is high for exactly one cycle, and that is the first cycle in which `sck` shows the non-idle level.
- R6: `trail_pulse` is high for exactly one cycle, and that is the first cycle in which `sck` is back at idle. The two strobes are never high together.
- R7: Changes to `div_sel`, `baud` and `cpol` while `en` is high have no effect on `sck` until `en` has been low for at least one rising edge.
- R8: When `en` is sampled low, `sck` returns to idle in the next cycle and no strobe is produced. On the next enable, counting restarts from zero, so the first departure again takes a full H cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; settings are captured while low |
| div_sel | input | 2 | Power-of-two prescale select D |
| baud | input | 6 | Baud count B, clamped to 4..63 |
| cpol | input | 1 | Idle level of the serial clock |
| sck | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle strobe as sck leaves idle |
| trail_pulse | output | 1 | One-cycle strobe as sck returns to idle |

## Verification
The divide path is exercised with a table of settings:
- All four prescale selects, paired with low, middle and top baud values. This separates the prescale stage from the baud stage.
- Baud values 0 and 3, which must give the same rate as 4.
- Both polarities, so that an inverted idle level is distinguished from a shifted phase.

For each setting, the bench counts cycles to the first departure and to the return. It also checks that no strobe appears between them, which catches off-by-one errors in either counter. Directed cases cover the following:
- Reset defaults that apply when `en` is held high.
- Settings that change in the middle of a transfer.
- An abort while the clock is active, followed by a restart.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    localparam int DIV_W   = 2;
    localparam int BRG_W   = 6;
    localparam int BRG_MIN = 4;
    localparam int BRG_RST = 4;
    localparam int DIV_RST = 0;
    // prescaler terminal count (2 << D) - 1 needs 2^DIV_W bits
    localparam int PRE_W   = 1 << DIV_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [BRG_W-1:0] brg;
        logic             cpol;
    } spiclk_cfg_t;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } spiclk_phase_e;

    localparam spiclk_cfg_t CFG_RST = '{
        div:  DIV_W'(DIV_RST),
        brg:  BRG_W'(BRG_RST),
        cpol: 1'b0
    };

    function automatic logic [BRG_W-1:0] clamp_brg(input logic [BRG_W-1:0] v);
        return (v < BRG_W'(BRG_MIN)) ? BRG_W'(BRG_MIN) : v;
    endfunction

    function automatic logic [PRE_W-1:0] pre_last(input logic [DIV_W-1:0] d);
        logic [PRE_W:0] full;
        full = (PRE_W+1)'(2) << d;
        return PRE_W'(full - 1'b1);
    endfunction

endpackage

// File: rtl/spiclk_cfg_shadow.sv
module spiclk_cfg_shadow
    import spiclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  spiclk_cfg_t cfg_in,
    output spiclk_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
        end else if (!en) begin
            cfg_q.div  <= cfg_in.div;
            cfg_q.brg  <= clamp_brg(cfg_in.brg);
            cfg_q.cpol <= cfg_in.cpol;
        end
    end

endmodule

// File: rtl/spiclk_prescaler.sv
module spiclk_prescaler
    import spiclk_pkg::*;
#(
    parameter int SEL_W = DIV_W,
    parameter int CNT_W = PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] div,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(pre_last(div));
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spiclk_baud_ctr.sv
module spiclk_baud_ctr
    import spiclk_pkg::*;
#(
    parameter int CNT_W = BRG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] brg,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt;

    assign wrap = tick && (cnt == brg);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spiclk_edge_gen.sv
module spiclk_edge_gen
    import spiclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wrap,
    input  logic cpol,
    output logic sck,
    output logic lead,
    output logic trail
);

    spiclk_phase_e phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_IDLE;
            lead  <= 1'b0;
            trail <= 1'b0;
        end else begin
            lead  <= wrap && (phase == PH_IDLE);
            trail <= wrap && (phase == PH_ACTIVE);
            if (wrap) begin
                phase <= (phase == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
            end
        end
    end

    assign sck = (phase == PH_ACTIVE) ^ cpol;

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
    import spiclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [BRG_W-1:0] baud,
    input  logic             cpol,
    output logic             sck,
    output logic             lead_pulse,
    output logic             trail_pulse
);

    spiclk_cfg_t cfg_in;
    spiclk_cfg_t cfg_q;
    logic        pre_tick;
    logic        baud_wrap;

    assign cfg_in = '{div: div_sel, brg: baud, cpol: cpol};

    spiclk_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    spiclk_prescaler #(.SEL_W(DIV_W), .CNT_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .div  (cfg_q.div),
        .tick (pre_tick)
    );

    spiclk_baud_ctr #(.CNT_W(BRG_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .tick (pre_tick),
        .brg  (cfg_q.brg),
        .wrap (baud_wrap)
    );

    spiclk_edge_gen u_edge (
        .clk   (clk),
        .rst   (rst),
        .run   (en),
        .wrap  (baud_wrap),
        .cpol  (cfg_q.cpol),
        .sck   (sck),
        .lead  (lead_pulse),
        .trail (trail_pulse)
    );

endmodule

// File: rtl/spiclk_gen_chk.sv
module spiclk_gen_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic sck,
    input logic lead_pulse,
    input logic trail_pulse
);

    AST_LEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lead_pulse |=> !lead_pulse); // R5

    AST_LEAD_MOVES_SCK: assert property (@(posedge clk) disable iff (rst)
        lead_pulse |-> (sck != $past(sck))); // R5

    AST_TRAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        trail_pulse |=> !trail_pulse); // R6

    AST_TRAIL_MOVES_SCK: assert property (@(posedge clk) disable iff (rst)
        trail_pulse |-> (sck != $past(sck))); // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({lead_pulse, trail_pulse}) <= 1); // R6

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> (!lead_pulse && !trail_pulse)); // R8

    AST_RUN_CHANGE_STROBED: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst) && (sck != $past(sck))) |-> (lead_pulse || trail_pulse)); // R4

endmodule

bind spiclk_gen spiclk_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .sck         (sck),
    .lead_pulse  (lead_pulse),
    .trail_pulse (trail_pulse)
);

// File: tb/spiclk_gen_test.sv
`timescale 1ns/1ps
module spiclk_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] div_sel = '0;
    logic [5:0] baud = 6'd4;
    logic       cpol = 1'b0;
    logic       sck, lead_pulse, trail_pulse;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spiclk_gen uut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .div_sel     (div_sel),
        .baud        (baud),
        .cpol        (cpol),
        .sck         (sck),
        .lead_pulse  (lead_pulse),
        .trail_pulse (trail_pulse)
    );

    typedef struct packed {
        logic [1:0]  d;
        logic [5:0]  b;
        logic        c;
        logic [10:0] h;
    } vec_t;

    // half period H = 2^(D+1) * (max(B,4)+1)
    localparam vec_t VEC [9] = '{
        '{d: 2'd0, b: 6'd4,  c: 1'b0, h: 11'd10},
        '{d: 2'd0, b: 6'd0,  c: 1'b1, h: 11'd10},
        '{d: 2'd1, b: 6'd5,  c: 1'b0, h: 11'd24},
        '{d: 2'd2, b: 6'd10, c: 1'b1, h: 11'd88},
        '{d: 2'd3, b: 6'd63, c: 1'b0, h: 11'd1024},
        '{d: 2'd0, b: 6'd3,  c: 1'b1, h: 11'd10},
        '{d: 2'd3, b: 6'd4,  c: 1'b1, h: 11'd80},
        '{d: 2'd1, b: 6'd63, c: 1'b0, h: 11'd256},
        '{d: 2'd2, b: 6'd4,  c: 1'b0, h: 11'd40}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        int pulses;
        int bad_lvl;
        tag = (v.b < 6'd4) ? "R2" : "R1";
        en = 1'b0; div_sel = v.d; baud = v.b; cpol = v.c;
        step(2);
        chk("R4", "idle level while disabled", int'(sck), int'(v.c));
        en = 1'b1;
        pulses = 0; bad_lvl = 0;
        for (int i = 1; i < int'(v.h); i++) begin
            step(1);
            pulses += int'(lead_pulse) + int'(trail_pulse);
            if (sck != v.c) bad_lvl++;
        end
        chk(tag, "strobes before first departure", pulses, 0);
        chk("R4", "off-idle cycles before departure", bad_lvl, 0);
        step(1);
        chk(tag, "lead at edge H", int'(lead_pulse), 1);
        chk("R5", "sck active with lead", int'(sck), int'(!v.c));
        chk("R6", "no trail with lead", int'(trail_pulse), 0);
        step(1);
        chk("R5", "lead one cycle", int'(lead_pulse), 0);
        pulses = 0; bad_lvl = 0;
        for (int i = 0; i < int'(v.h) - 2; i++) begin
            step(1);
            pulses += int'(lead_pulse) + int'(trail_pulse);
            if (sck == v.c) bad_lvl++;
        end
        chk(tag, "strobes inside active half", pulses, 0);
        chk(tag, "idle cycles inside active half", bad_lvl, 0);
        step(1);
        chk(tag, "trail at edge 2H", int'(trail_pulse), 1);
        chk("R6", "sck idle with trail", int'(sck), int'(v.c));
        chk("R6", "no lead with trail", int'(lead_pulse), 0);
        step(1);
        chk("R6", "trail one cycle", int'(trail_pulse), 0);
        en = 1'b0;
    endtask

    initial begin
        // R3: reset state and defaults with en held high
        rst = 1'b1; en = 1'b1; div_sel = 2'd3; baud = 6'd63; cpol = 1'b1;
        step(3);
        chk("R3", "sck in reset", int'(sck), 0);
        chk("R3", "strobes in reset", int'(lead_pulse) + int'(trail_pulse), 0);
        rst = 1'b0;
        step(9);
        chk("R3", "no departure before default H", int'(sck), 0);
        step(1);
        chk("R3", "default H=10 lead", int'(lead_pulse), 1);
        chk("R3", "default polarity active high", int'(sck), 1);

        // table of settings
        for (int k = 0; k < 9; k++) run_vec(VEC[k]);

        // R7: settings changed mid-transfer are ignored
        en = 1'b0; div_sel = 2'd0; baud = 6'd4; cpol = 1'b0;
        step(2);
        en = 1'b1;
        step(10);
        chk("R7", "lead at 10", int'(lead_pulse), 1);
        div_sel = 2'd3; baud = 6'd63; cpol = 1'b1;
        step(10);
        chk("R7", "trail still at 20", int'(trail_pulse), 1);
        chk("R7", "polarity unchanged", int'(sck), 0);
        step(10);
        chk("R7", "second lead at 30", int'(lead_pulse), 1);
        chk("R7", "active level unchanged", int'(sck), 1);

        // R8: abort while active, then restart
        div_sel = 2'd0; baud = 6'd4; cpol = 1'b0; en = 1'b0;
        step(1);
        chk("R8", "sck idle after abort", int'(sck), 0);
        chk("R8", "no strobe on abort", int'(lead_pulse) + int'(trail_pulse), 0);
        en = 1'b1;
        begin
            int early;
            early = 0;
            for (int i = 0; i < 9; i++) begin
                step(1);
                early += int'(lead_pulse) + int'(sck);
            end
            chk("R8", "restart not early", early, 0);
        end
        step(1);
        chk("R8", "restart full H", int'(lead_pulse), 1);
        en = 1'b0;
        step(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule